// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a byte-wide flash memory with a static-RAM-style bus: chip select, read strobe and write strobe, all active low, plus an address and a data byte. The host changes the memory by writing command bytes. Single-byte writes select what a read returns: array contents, the status byte or two identification codes. Two-write sequences start an internal sequencer that programs one byte or erases one block. The array is a plain behavioural register file inside the block. Fixed cycle counts stand in for real program and erase times.

Programming can only clear bits: the stored byte becomes old AND new. An erase writes FFh to each byte of the selected block, one byte per clock, so an erase lasts as many cycles as the block has bytes. An erase can be paused so that other blocks can be read, and then continued. A status byte reports readiness and sticky error flags. A program-voltage-good input and an active-low reset/power-down input are plain digital signals.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and after `rp_n` returns high, reads return array data with no command written. Status then reads 80h: bit 7 is ready, bit 6 is suspended, bit 5 is erase error, bit 4 is program error, bit 3 is low program voltage, and bits 2..0 are zero.
- R2: Writing 40h and then a data byte at an address programs that address with old AND data. Status bit 7 reads 0 for exactly `PROG_CYC` cycles after the data write. Reads return status after the sequence.
- R3: Command FFh selects array reads and 70h selects status reads. Command 90h selects identifier reads: address bit 0 = 0 gives `MAKER_CODE` and address bit 0 = 1 gives `DEVICE_CODE`.
- R4: Writing 20h and then D0h starts an erase of the block that holds the address (2^`BLK_W` bytes). The block is busy for 2^`BLK_W` cycles and every byte in it then reads FFh. Other blocks keep their contents.
- R5: If the write after 20h is not D0h, status bit 5 is set and no byte changes.
- R6: A program or erase started while `vpp_ok` is low sets bit 3 together with bit 4 (program) or bit 5 (erase), and leaves the array unchanged.
- R7: While bit 3 is set, program and erase sequences are refused. No byte changes and the status stays the same until 50h clears bits 3, 4 and 5.
- R8: A program whose result differs from the data written sets bit 4. Bit 4 stays set through later successful programs and only 50h clears it.
- R9: Writing B0h during an erase stops the erase in the next cycle, and status reads C0h. Other blocks, and the bytes of the erased block not yet reached, can then be read. Writing D0h continues the erase from where it stopped.
- R10: While `rp_n` is low, bus writes are ignored, a running operation is abandoned and `dq_oe` is low.
- R11: `dq_oe` is high only when `ce_n` and `oe_n` are low and `we_n` and `rp_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rp_n | input | 1 | Active-low reset/power-down; clears control state and blocks writes |
| vpp_ok | input | 1 | Program voltage present |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low; one write per clock it is sampled low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data or command byte |
| dq_out | output | 8 | Read data: array, status or identifier |
| dq_oe | output | 1 | Read data valid / output enable |

## Verification
The bench builds the block with an 8-bit address, 64-byte blocks and an 8-cycle program time. This gives four blocks and a 64-cycle erase, so the whole array can be erased and compared byte by byte against the model. It also allows exact cycle counts across a suspend and a resume in the middle of an erase. It allows an erase to be cut off by `rp_n` after a known number of bytes.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    MD_ARRAY,
    MD_STATUS,
    MD_IDENT,
    MD_PSETUP,
    MD_ESETUP
  } mode_e;

  localparam logic [DW-1:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [DW-1:0] OP_PROG_SETUP  = 8'h40;
  localparam logic [DW-1:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [DW-1:0] OP_CONFIRM     = 8'hD0;
  localparam logic [DW-1:0] OP_SUSPEND     = 8'hB0;
  localparam logic [DW-1:0] OP_CLR_STATUS  = 8'h50;
  localparam logic [DW-1:0] OP_READ_STATUS = 8'h70;
  localparam logic [DW-1:0] OP_READ_IDENT  = 8'h90;
endpackage

// File: rtl/flash_array.sv
`timescale 1ns/1ps
module flash_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data_a = cells[rd_addr_a];
  assign rd_data_b = cells[rd_addr_b];
endmodule

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
module flash_seq #(
  parameter int AW       = 8,
  parameter int BW       = 6,
  parameter int PROG_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic          suspend_req,
  input  logic          resume_req,
  input  logic [7:0]    old_byte,
  output logic          busy,
  output logic          suspended,
  output logic          erasing,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          prog_fail
);
  localparam int PW = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
  localparam int CW = (BW > PW) ? BW : PW;
  localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] BLK_LAST  = CW'((1 << BW) - 1);

  logic          busy_q, busy_d, susp_q, susp_d, erase_q, erase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    data_q, data_d;
  logic          step;

  always_comb begin
    busy_d    = busy_q;
    susp_d    = susp_q;
    erase_d   = erase_q;
    cnt_d     = cnt_q;
    addr_d    = addr_q;
    data_d    = data_q;
    mem_we    = 1'b0;
    mem_wdata = data_q;
    prog_fail = 1'b0;
    mem_addr  = erase_q ? {addr_q[AW-1:BW], cnt_q[BW-1:0]} : addr_q;
    step      = busy_q && !susp_q && !suspend_req && !abort;
    if (step) begin
      if (erase_q) begin
        mem_we    = 1'b1;
        mem_wdata = '1;
        if (cnt_q == BLK_LAST) busy_d = 1'b0;
        else                   cnt_d  = cnt_q + 1'b1;
      end else if (cnt_q == '0) begin
        mem_we    = 1'b1;
        mem_wdata = old_byte & data_q;
        prog_fail = ((old_byte & data_q) != data_q);
        busy_d    = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (suspend_req) susp_d = 1'b1;
    if (resume_req)  susp_d = 1'b0;
    if (start_prog) begin
      busy_d  = 1'b1;
      erase_d = 1'b0;
      cnt_d   = PROG_LAST;
      addr_d  = cmd_addr;
      data_d  = cmd_data;
    end
    if (start_erase) begin
      busy_d  = 1'b1;
      erase_d = 1'b1;
      cnt_d   = '0;
      addr_d  = cmd_addr;
    end
    if (abort) begin
      busy_d = 1'b0;
      susp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      susp_q  <= 1'b0;
      erase_q <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      susp_q  <= susp_d;
      erase_q <= erase_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign busy      = busy_q;
  assign suspended = susp_q;
  assign erasing   = busy_q && erase_q;
endmodule

// File: rtl/flash_cmd_decode.sv
`timescale 1ns/1ps
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       wr,
  input  logic [7:0] wr_byte,
  input  logic       vpp_ok,
  input  logic       busy,
  input  logic       erasing,
  input  logic       suspended,
  input  logic       prog_fail,
  output mode_e      mode,
  output logic       start_prog,
  output logic       start_erase,
  output logic       suspend_req,
  output logic       resume_req,
  output logic       sr_vpp,
  output logic       sr_prog,
  output logic       sr_erase
);
  mode_e mode_q, mode_d;
  logic  vpp_q, vpp_d, prog_q, prog_d, erase_q, erase_d;

  always_comb begin
    mode_d      = mode_q;
    vpp_d       = vpp_q;
    prog_d      = prog_q | prog_fail;
    erase_d     = erase_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    suspend_req = 1'b0;
    resume_req  = 1'b0;
    if (wr) begin
      if (busy && !suspended) begin
        if (erasing && wr_byte == OP_SUSPEND) suspend_req = 1'b1;
        if (wr_byte == OP_READ_STATUS) mode_d = MD_STATUS;
      end else if (suspended) begin
        case (wr_byte)
          OP_READ_ARRAY:  mode_d = MD_ARRAY;
          OP_READ_STATUS: mode_d = MD_STATUS;
          OP_READ_IDENT:  mode_d = MD_IDENT;
          OP_CONFIRM: begin
            resume_req = 1'b1;
            mode_d     = MD_STATUS;
          end
          default: ;
        endcase
      end else begin
        case (mode_q)
          MD_PSETUP: begin
            mode_d = MD_STATUS;
            if (!vpp_q) begin
              if (!vpp_ok) begin
                vpp_d  = 1'b1;
                prog_d = 1'b1;
              end else begin
                start_prog = 1'b1;
              end
            end
          end
          MD_ESETUP: begin
            mode_d = MD_STATUS;
            if (wr_byte != OP_CONFIRM) begin
              erase_d = 1'b1;
            end else if (!vpp_q) begin
              if (!vpp_ok) begin
                vpp_d   = 1'b1;
                erase_d = 1'b1;
              end else begin
                start_erase = 1'b1;
              end
            end
          end
          default: begin
            case (wr_byte)
              OP_READ_ARRAY:  mode_d = MD_ARRAY;
              OP_READ_STATUS: mode_d = MD_STATUS;
              OP_READ_IDENT:  mode_d = MD_IDENT;
              OP_PROG_SETUP:  mode_d = MD_PSETUP;
              OP_ERASE_SETUP: mode_d = MD_ESETUP;
              OP_CLR_STATUS: begin
                vpp_d   = 1'b0;
                prog_d  = 1'b0;
                erase_d = 1'b0;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
    if (abort) begin
      mode_d  = MD_ARRAY;
      vpp_d   = 1'b0;
      prog_d  = 1'b0;
      erase_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_ARRAY;
      vpp_q   <= 1'b0;
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      vpp_q   <= vpp_d;
      prog_q  <= prog_d;
      erase_q <= erase_d;
    end
  end

  assign mode     = mode_q;
  assign sr_vpp   = vpp_q;
  assign sr_prog  = prog_q;
  assign sr_erase = erase_q;

  // R6: the low-voltage flag only appears after an attempt made with vpp_ok low
  assert_vpp_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_q) |-> $past(!vpp_ok));
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          BLK_W       = 6,
  parameter int          PROG_CYC    = 8,
  parameter logic [7:0]  MAKER_CODE  = 8'h5A,
  parameter logic [7:0]  DEVICE_CODE = 8'hA3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              vpp_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  mode_e             mode;
  logic              wr, abort;
  logic              start_prog, start_erase, suspend_req, resume_req;
  logic              busy, suspended, erasing, prog_fail;
  logic              sr_vpp, sr_prog, sr_erase;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, old_byte, array_byte, status;

  assign abort = !rp_n;
  assign wr    = !ce_n && !we_n && rp_n;
  assign dq_oe = !ce_n && !oe_n && we_n && rp_n;

  flash_cmd_decode u_decode (
    .clk(clk), .rst_n(rst_n), .abort(abort), .wr(wr), .wr_byte(dq_in),
    .vpp_ok(vpp_ok), .busy(busy), .erasing(erasing), .suspended(suspended),
    .prog_fail(prog_fail), .mode(mode), .start_prog(start_prog),
    .start_erase(start_erase), .suspend_req(suspend_req), .resume_req(resume_req),
    .sr_vpp(sr_vpp), .sr_prog(sr_prog), .sr_erase(sr_erase)
  );

  flash_seq #(.AW(ADDR_W), .BW(BLK_W), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(abort), .start_prog(start_prog),
    .start_erase(start_erase), .cmd_addr(addr), .cmd_data(dq_in),
    .suspend_req(suspend_req), .resume_req(resume_req), .old_byte(old_byte),
    .busy(busy), .suspended(suspended), .erasing(erasing), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .prog_fail(prog_fail)
  );

  flash_array #(.AW(ADDR_W), .DW(DW)) u_array (
    .clk(clk), .wr_en(mem_we), .wr_addr(mem_addr), .wr_data(mem_wdata),
    .rd_addr_a(addr), .rd_data_a(array_byte),
    .rd_addr_b(mem_addr), .rd_data_b(old_byte)
  );

  assign status = {(!busy || suspended), suspended, sr_erase, sr_prog, sr_vpp, 3'b000};

  always_comb begin
    if (busy && !suspended) begin
      dq_out = status;
    end else begin
      case (mode)
        MD_ARRAY: dq_out = array_byte;
        MD_IDENT: dq_out = addr[0] ? DEVICE_CODE : MAKER_CODE;
        default:  dq_out = status;
      endcase
    end
  end

  // R2: an accepted data write puts the sequencer into a program operation
  assert_prog_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> busy && !erasing);
  // R9: a pause can only exist inside an erase
  assert_suspend_in_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> erasing);
  // R10: the array is never written while rp_n is low
  assert_no_write_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> rp_n);
  // R8: a failed byte program is reflected in bit 4 one cycle later
  assert_prog_error_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fail |=> sr_prog);
  // R7: no operation starts while the low-voltage flag stands
  assert_locked_by_vpp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |-> !sr_vpp);
endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int AW = 8, BW = 6, PCYC = 8;
  localparam int BLK = 1 << BW, DEPTH = 1 << AW;
  localparam logic [7:0] MAKER = 8'h5A, DEVICE = 8'hA3;
  localparam int MA = 0, MS = 1, MI = 2, MP = 3, ME = 4;

  logic clk = 1'b0, rst_n = 1'b0, rp_n = 1'b1, vpp_ok = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic dq_oe;

  int checks = 0, errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BLK_W(BW), .PROG_CYC(PCYC),
                   .MAKER_CODE(MAKER), .DEVICE_CODE(DEVICE)) uut (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .vpp_ok(vpp_ok), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe));

  // behavioural reference model
  int m_mem [DEPTH];
  int m_mode, m_cnt, m_addr, ob;
  bit m_busy, m_susp, m_er, v3, v4, v5, pb, ps, sreq, mwr;
  logic [7:0] m_data, nv;

  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = -1;

  function automatic logic [7:0] m_status();
    return {(!m_busy || m_susp), m_susp, v5, v4, v3, 3'b000};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = MA; m_busy = 0; m_susp = 0; m_er = 0; v3 = 0; v4 = 0; v5 = 0; m_cnt = 0;
    end else if (!rp_n) begin
      m_mode = MA; m_busy = 0; m_susp = 0; v3 = 0; v4 = 0; v5 = 0;
    end else begin
      mwr  = !ce_n && !we_n;
      pb   = m_busy;
      ps   = m_susp;
      sreq = mwr && m_busy && m_er && !m_susp && dq_in == 8'hB0;
      if (m_busy && !m_susp && !sreq) begin
        if (m_er) begin
          m_mem[(m_addr / BLK) * BLK + m_cnt] = 255;
          if (m_cnt == BLK - 1) m_busy = 0; else m_cnt++;
        end else if (m_cnt == 0) begin
          ob = m_mem[m_addr];
          nv = ob[7:0] & m_data;
          if (nv != m_data) v4 = 1;
          m_mem[m_addr] = int'(nv);
          m_busy = 0;
        end else m_cnt--;
      end
      if (mwr) begin
        if (pb && !ps) begin
          if (sreq) m_susp = 1;
          if (dq_in == 8'h70) m_mode = MS;
        end else if (ps) begin
          case (dq_in)
            8'hFF: m_mode = MA;
            8'h70: m_mode = MS;
            8'h90: m_mode = MI;
            8'hD0: begin m_susp = 0; m_mode = MS; end
            default: ;
          endcase
        end else if (m_mode == MP) begin
          m_mode = MS;
          if (!v3) begin
            if (!vpp_ok) begin v3 = 1; v4 = 1; end
            else begin m_busy = 1; m_er = 0; m_cnt = PCYC - 1; m_addr = int'(addr); m_data = dq_in; end
          end
        end else if (m_mode == ME) begin
          m_mode = MS;
          if (dq_in != 8'hD0) v5 = 1;
          else if (!v3) begin
            if (!vpp_ok) begin v3 = 1; v5 = 1; end
            else begin m_busy = 1; m_er = 1; m_cnt = 0; m_addr = int'(addr); end
          end
        end else begin
          case (dq_in)
            8'hFF: m_mode = MA;
            8'h70: m_mode = MS;
            8'h90: m_mode = MI;
            8'h40: m_mode = MP;
            8'h20: m_mode = ME;
            8'h50: begin v3 = 0; v4 = 0; v5 = 0; end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  logic exp_oe, known;
  logic [7:0] exp_q;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_oe = !ce_n && !oe_n && we_n && rp_n;
      chk("R11", "model dq_oe", {7'b0, dq_oe}, {7'b0, exp_oe});
      if (exp_oe) begin
        known = 1'b1;
        exp_q = m_status();
        if (!(m_busy && !m_susp)) begin
          if (m_mode == MA) begin
            if (m_mem[addr] < 0) known = 1'b0; else exp_q = m_mem[addr][7:0];
          end else if (m_mode == MI) exp_q = addr[0] ? DEVICE : MAKER;
        end
        if (known) chk(phase, "model dq_out", dq_out, exp_q);
      end
    end
  end

  task automatic wr_cmd(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; dq_in = d;
    @(posedge clk); #1;
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk);
    d = dq_out;
  endtask

  task automatic wait_ready(output int n);
    ce_n = 0; oe_n = 0; we_n = 1;
    n = 0;
    forever begin
      @(negedge clk);
      if (dq_out[7] || n > 1000) break;
      n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, output int n);
    wr_cmd(a, 8'h40);
    wr_cmd(a, d);
    wait_ready(n);
  endtask

  logic [7:0] r;
  int n;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11", "dq_oe with chip deselected", {7'b0, dq_oe}, 8'h00);

    phase = "R1";
    wr_cmd(0, 8'h70); rd(0, r); chk("R1", "status after reset", r, 8'h80);
    phase = "R3";
    wr_cmd(0, 8'h90);
    rd(0, r); chk("R3", "maker code", r, MAKER);
    rd(1, r); chk("R3", "device code", r, DEVICE);

    phase = "R4";
    for (int b = 0; b < DEPTH / BLK; b++) begin
      wr_cmd(AW'(b * BLK), 8'h20);
      wr_cmd(AW'(b * BLK), 8'hD0);
      wait_ready(n);
      if (b == 0) chk("R4", "erase busy cycles", 8'(n), 8'(BLK));
      chk("R4", "status after erase", dq_out, 8'h80);
    end
    wr_cmd(0, 8'hFF);
    rd(8'h05, r); chk("R4", "erased byte", r, 8'hFF);
    rd(8'hC7, r); chk("R3", "array read after FFh", r, 8'hFF);

    phase = "R2";
    prog(8'h10, 8'hA5, n);
    chk("R2", "program busy cycles", 8'(n), 8'(PCYC));
    chk("R2", "status after program", dq_out, 8'h80);
    wr_cmd(0, 8'hFF); rd(8'h10, r); chk("R2", "programmed byte", r, 8'hA5);

    phase = "R8";
    prog(8'h10, 8'h5A, n); chk("R8", "status after failed program", dq_out, 8'h90);
    prog(8'h11, 8'h0F, n); chk("R8", "bit 4 sticky", dq_out, 8'h90);
    wr_cmd(0, 8'hFF);
    rd(8'h11, r); chk("R2", "good program with bit 4 set", r, 8'h0F);
    rd(8'h10, r); chk("R8", "AND result", r, 8'h00);
    wr_cmd(0, 8'h50); wr_cmd(0, 8'h70); rd(0, r); chk("R8", "status after clear", r, 8'h80);

    phase = "R6";
    vpp_ok = 0;
    wr_cmd(8'h20, 8'h40); wr_cmd(8'h20, 8'h00);
    rd(8'h20, r); chk("R6", "program with vpp low", r, 8'h98);
    phase = "R7";
    vpp_ok = 1;
    wr_cmd(8'h20, 8'h40); wr_cmd(8'h20, 8'h00);
    rd(8'h20, r); chk("R7", "program refused", r, 8'h98);
    wr_cmd(8'h40, 8'h20); wr_cmd(8'h40, 8'hD0);
    rd(8'h40, r); chk("R7", "erase refused", r, 8'h98);
    wr_cmd(0, 8'hFF);
    rd(8'h20, r); chk("R6", "byte unchanged", r, 8'hFF);
    wr_cmd(0, 8'h50); wr_cmd(0, 8'h70); rd(0, r); chk("R7", "status cleared", r, 8'h80);
    prog(8'h20, 8'h33, n);
    wr_cmd(0, 8'hFF); rd(8'h20, r); chk("R7", "program after clear", r, 8'h33);

    phase = "R6";
    vpp_ok = 0;
    wr_cmd(8'h80, 8'h20); wr_cmd(8'h80, 8'hD0);
    rd(8'h80, r); chk("R6", "erase with vpp low", r, 8'hA8);
    vpp_ok = 1;
    wr_cmd(0, 8'h50);

    phase = "R5";
    prog(8'hC0, 8'h12, n);
    wr_cmd(8'hC0, 8'h20); wr_cmd(8'hC0, 8'hFF);
    rd(8'hC0, r); chk("R5", "bad confirm", r, 8'hA0);
    wr_cmd(0, 8'hFF); rd(8'hC0, r); chk("R5", "no erase", r, 8'h12);
    wr_cmd(0, 8'h50);

    phase = "R9";
    prog(8'h80, 8'h55, n);
    prog(8'h7E, 8'h00, n);
    prog(8'hBE, 8'h00, n);
    wr_cmd(8'h40, 8'h20); wr_cmd(8'h40, 8'hD0);
    idle(5);
    wr_cmd(8'h40, 8'hB0);
    rd(8'h40, r); chk("R9", "suspended status", r, 8'hC0);
    idle(4);
    rd(8'h40, r); chk("R9", "still suspended", r, 8'hC0);
    wr_cmd(0, 8'hFF);
    rd(8'h7E, r); chk("R9", "unreached byte kept", r, 8'h00);
    rd(8'h80, r); chk("R9", "other block readable", r, 8'h55);
    wr_cmd(8'h40, 8'hD0);
    wait_ready(n);
    chk("R9", "remaining erase cycles", 8'(n), 8'(BLK - 6));
    chk("R9", "status after resume", dq_out, 8'h80);
    wr_cmd(0, 8'hFF);
    rd(8'h7E, r); chk("R9", "erase completed", r, 8'hFF);
    rd(8'h80, r); chk("R4", "other block untouched", r, 8'h55);

    phase = "R10";
    wr_cmd(8'h80, 8'h20); wr_cmd(8'h80, 8'hD0);
    idle(3);
    rp_n = 0; ce_n = 0; oe_n = 0;
    @(negedge clk);
    chk("R10", "dq_oe in power-down", {7'b0, dq_oe}, 8'h00);
    wr_cmd(8'h81, 8'h40); wr_cmd(8'h81, 8'h00);
    @(posedge clk); #1 rp_n = 1;
    phase = "R1";
    rd(8'hBE, r); chk("R10", "erase abandoned", r, 8'h00);
    rd(8'h81, r); chk("R10", "writes ignored", r, 8'hFF);
    wr_cmd(0, 8'h70); rd(0, r); chk("R1", "status after rp_n", r, 8'h80);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule